// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps speculative results of an out-of-order core in program order until they can safely become architectural. Each issued instruction claims one slot at the tail of a circular buffer and receives that slot's index as its tag. The tag is what reservation stations wait on and what the result bus carries. When a result is broadcast, the matching slot records the value, a side address (the store address or the corrected next PC of a branch), an exception flag and the resolved branch direction.

Retirement happens only at the head, at most once per cycle, and only when the head slot holds its result. What retirement does depends on the slot:
- An arithmetic result goes to the register file.
- A store updates memory.
- A recorded exception is raised.
- A branch whose resolved direction differs from its prediction empties the whole buffer and redirects fetch.

The block also holds the register rename map. Issuing instructions look up their source registers there and pick up values that are finished but not yet retired.

Allocation is a valid/ready stream. The issue stage holds `alloc_valid` and its fields steady until `alloc_ready` is seen high at a clock edge, and a slot is taken only on such an edge. `alloc_ready` drops when the buffer is full, when no reservation station is free, or in a flush cycle. The result bus is a broadcast with no back-pressure. Retirement outputs are single-cycle pulses with no handshake.

Top module: `rob_top`

## Requirements
- R1: With an empty or partly filled buffer, `alloc_ready` equals `rs_free` (outside a flush cycle). Each accepted allocation takes the slot given by `alloc_tag`, and tags advance by one per allocation, modulo DEPTH. Kind encoding on `alloc_kind`: 0 = arithmetic, 1 = store, 2 = branch.
- R2: After DEPTH allocations with no retirement, `alloc_ready` is low and no slot is overwritten.
- R3: A result-bus write to an allocated slot captures value, address, exception flag and resolved direction, and marks the slot finished from the next cycle on.
- R4: For each source port, `src_pend` shows that the register is renamed and `src_tag` gives the producing slot. `src_hit` is high when that slot has finished, and `src_value` is then its captured value.
- R5: At most one slot retires per cycle, always the head, and only once it has finished. An arithmetic slot retires with `rf_we` high and `rf_waddr`/`rf_wdata` equal to its destination and value.
- R6: A store retires with `mem_we` high, `mem_addr`/`mem_wdata` equal to its captured address and value, and `rf_we` low.
- R7: When an arithmetic slot retires, its destination's rename entry is cleared only if it still names that slot. A later rename of the same register survives the retirement.
- R8: A finished head slot with its exception flag set raises `exc_raise` with `exc_tag` = head index. In that cycle `flush` is high and there is no register or memory write.
- R9: A branch at the head whose resolved direction differs from its prediction asserts `flush` and `redirect_valid`, with `redirect_pc` = its captured address. A correctly predicted branch retires with no flush.
- R10: In a flush cycle `alloc_ready` is low and result-bus writes are dropped. Afterwards the buffer and rename map are empty and the next allocation gets tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Issue stage offers an instruction |
| alloc_ready | output | 1 | Slot and station available; allocation happens on valid and ready |
| alloc_kind | input | 2 | 0 arithmetic, 1 store, 2 branch |
| alloc_dest | input | RW | Destination register (arithmetic only) |
| alloc_pred_taken | input | 1 | Predicted branch direction |
| rs_free | input | 1 | A reservation station is free for this instruction |
| alloc_tag | output | IW | Slot index the offered instruction receives |
| src_reg | input | NSRC x RW | Source registers to look up |
| src_pend | output | NSRC | Source register is renamed |
| src_tag | output | NSRC x IW | Producing slot of a renamed source |
| src_hit | output | NSRC | Producing slot has finished |
| src_value | output | NSRC x DW | Finished value of the producing slot |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | IW | Slot the result belongs to |
| cdb_value | input | DW | Result value or store data |
| cdb_addr | input | AW | Store address or corrected next PC |
| cdb_exc | input | 1 | Instruction faulted |
| cdb_taken | input | 1 | Resolved branch direction |
| rf_we | output | 1 | Register file write pulse |
| rf_waddr | output | RW | Register written |
| rf_wdata | output | DW | Value written |
| mem_we | output | 1 | Memory write pulse |
| mem_addr | output | AW | Store address |
| mem_wdata | output | DW | Store data |
| exc_raise | output | 1 | Exception taken at the head |
| exc_tag | output | IW | Slot that faulted |
| flush | output | 1 | Whole buffer and stations are discarded this cycle |
| redirect_valid | output | 1 | Fetch restarts at redirect_pc |
| redirect_pc | output | AW | Corrected fetch address |

## Verification
Retirement at the head and allocation at the tail often fall in the same cycle. They matter most when both touch the same architectural register: an arithmetic instruction retires while a newer writer of its destination is being renamed. The bench keeps destinations in a pool of four registers and issues almost every cycle, so this overlap recurs throughout the run. A behavioural model judges the outcome each cycle by comparing the rename lookup (pending flag and tag) and the register-file write port against its own expected values. The same overlap is also judged between retirement and a result-bus write, and between a flush and a pending allocation or broadcast.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2
  } kind_e;
endpackage

// File: rtl/rob_ptrs.sv
// Head/tail pointers of the circular buffer; an extra wrap bit per pointer
// separates full from empty.
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  output logic [IW-1:0] head_idx,
  output logic [IW-1:0] tail_idx,
  output logic          full,
  output logic          empty
);
  logic [IW-1:0] h_q, t_q;
  logic          hw_q, tw_q;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + IW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0; t_q <= '0; hw_q <= 1'b0; tw_q <= 1'b0;
    end else if (flush) begin
      h_q <= '0; t_q <= '0; hw_q <= 1'b0; tw_q <= 1'b0;
    end else begin
      if (push) begin
        t_q <= step(t_q);
        if (t_q == IW'(DEPTH - 1)) tw_q <= ~tw_q;
      end
      if (pop) begin
        h_q <= step(h_q);
        if (h_q == IW'(DEPTH - 1)) hw_q <= ~hw_q;
      end
    end
  end

  assign head_idx = h_q;
  assign tail_idx = t_q;
  assign empty    = (h_q == t_q) && (hw_q == tw_q);
  assign full     = (h_q == t_q) && (hw_q != tw_q);

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_tail_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |=> tail_idx == step($past(tail_idx)));
  assert_head_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |=> head_idx == step($past(head_idx)));
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/rob_map.sv
// Register rename map: which slot will produce each architectural register.
module rob_map #(
  parameter int NREG  = 16,
  parameter int DEPTH = 8,
  parameter int NSRC  = 2,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     set_en,
  input  logic [RW-1:0]            set_reg,
  input  logic [IW-1:0]            set_tag,
  input  logic                     clr_en,
  input  logic [RW-1:0]            clr_reg,
  input  logic [IW-1:0]            clr_tag,
  input  logic [NSRC-1:0][RW-1:0]  look_reg,
  output logic [NSRC-1:0]          look_pend,
  output logic [NSRC-1:0][IW-1:0]  look_tag
);
  logic [NREG-1:0] busy_q;
  logic [IW-1:0]   tag_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int r = 0; r < NREG; r++) tag_q[r] <= '0;
    end else if (flush) begin
      busy_q <= '0;
    end else begin
      // Retirement clears only a mapping that still names the retiring slot;
      // a same-cycle rename is written afterwards and wins.
      if (clr_en && busy_q[clr_reg] && (tag_q[clr_reg] == clr_tag))
        busy_q[clr_reg] <= 1'b0;
      if (set_en) begin
        busy_q[set_reg] <= 1'b1;
        tag_q[set_reg]  <= set_tag;
      end
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_look
    assign look_pend[s] = busy_q[look_reg[s]];
    assign look_tag[s]  = tag_q[look_reg[s]];
  end

  assert_newer_rename_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !flush && busy_q[clr_reg] && (tag_q[clr_reg] != clr_tag))
      |=> busy_q[$past(clr_reg)]);
  assert_own_rename_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !flush && (tag_q[clr_reg] == clr_tag) && !(set_en && set_reg == clr_reg))
      |=> !busy_q[$past(clr_reg)]);
endmodule

// File: rtl/rob_slots.sv
// Slot storage: per-slot fields, result capture and read ports.
module rob_slots
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREG  = 16,
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int NSRC  = 2,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     alloc_en,
  input  logic [IW-1:0]            alloc_idx,
  input  kind_e                    alloc_kind,
  input  logic [RW-1:0]            alloc_dest,
  input  logic                     alloc_pt,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [DW-1:0]            wr_val,
  input  logic [AW-1:0]            wr_addr,
  input  logic                     wr_exc,
  input  logic                     wr_taken,
  input  logic                     free_en,
  input  logic [IW-1:0]            free_idx,
  input  logic [IW-1:0]            head_idx,
  output kind_e                    h_kind,
  output logic [RW-1:0]            h_dest,
  output logic [DW-1:0]            h_val,
  output logic [AW-1:0]            h_addr,
  output logic                     h_rdy,
  output logic                     h_exc,
  output logic                     h_mispred,
  input  logic [NSRC-1:0][IW-1:0]  look_idx,
  output logic [NSRC-1:0]          look_rdy,
  output logic [NSRC-1:0][DW-1:0]  look_val
);
  kind_e         kind_q [DEPTH];
  logic [RW-1:0] dest_q [DEPTH];
  logic [DW-1:0] val_q  [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic [DEPTH-1:0] rdy_q, exc_q, pt_q, at_q, busy_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        kind_q[i] <= K_ALU; dest_q[i] <= '0; val_q[i] <= '0; addr_q[i] <= '0;
        rdy_q[i] <= 1'b0; exc_q[i] <= 1'b0; pt_q[i] <= 1'b0; at_q[i] <= 1'b0;
        busy_q[i] <= 1'b0;
      end else if (flush) begin
        rdy_q[i]  <= 1'b0;
        busy_q[i] <= 1'b0;
      end else begin
        if (free_en && free_idx == IW'(i)) begin
          busy_q[i] <= 1'b0;
          rdy_q[i]  <= 1'b0;
        end
        if (alloc_en && alloc_idx == IW'(i)) begin
          kind_q[i] <= alloc_kind;
          dest_q[i] <= alloc_dest;
          pt_q[i]   <= alloc_pt;
          busy_q[i] <= 1'b1;
          rdy_q[i]  <= 1'b0;
          exc_q[i]  <= 1'b0;
        end
        if (wr_en && busy_q[i] && wr_idx == IW'(i)) begin
          val_q[i]  <= wr_val;
          addr_q[i] <= wr_addr;
          exc_q[i]  <= wr_exc;
          at_q[i]   <= wr_taken;
          rdy_q[i]  <= 1'b1;
        end
      end
    end

    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_q[i] && !flush && !(free_en && free_idx == IW'(i))) |=> rdy_q[i]);
  end

  assign h_kind    = kind_q[head_idx];
  assign h_dest    = dest_q[head_idx];
  assign h_val     = val_q[head_idx];
  assign h_addr    = addr_q[head_idx];
  assign h_rdy     = rdy_q[head_idx];
  assign h_exc     = exc_q[head_idx];
  assign h_mispred = (kind_q[head_idx] == K_BRANCH) && (pt_q[head_idx] != at_q[head_idx]);

  for (genvar s = 0; s < NSRC; s++) begin : g_look
    assign look_rdy[s] = rdy_q[look_idx[s]];
    assign look_val[s] = val_q[look_idx[s]];
  end
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREG  = 16,
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int NSRC  = 2,
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_valid,
  output logic                     alloc_ready,
  input  logic [1:0]               alloc_kind,
  input  logic [RW-1:0]            alloc_dest,
  input  logic                     alloc_pred_taken,
  input  logic                     rs_free,
  output logic [IW-1:0]            alloc_tag,
  input  logic [NSRC-1:0][RW-1:0]  src_reg,
  output logic [NSRC-1:0]          src_pend,
  output logic [NSRC-1:0][IW-1:0]  src_tag,
  output logic [NSRC-1:0]          src_hit,
  output logic [NSRC-1:0][DW-1:0]  src_value,
  input  logic                     cdb_valid,
  input  logic [IW-1:0]            cdb_tag,
  input  logic [DW-1:0]            cdb_value,
  input  logic [AW-1:0]            cdb_addr,
  input  logic                     cdb_exc,
  input  logic                     cdb_taken,
  output logic                     rf_we,
  output logic [RW-1:0]            rf_waddr,
  output logic [DW-1:0]            rf_wdata,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [DW-1:0]            mem_wdata,
  output logic                     exc_raise,
  output logic [IW-1:0]            exc_tag,
  output logic                     flush,
  output logic                     redirect_valid,
  output logic [AW-1:0]            redirect_pc
);
  logic [IW-1:0] head_idx, tail_idx;
  logic          full, empty;
  kind_e         a_kind, h_kind;
  logic [RW-1:0] h_dest;
  logic [DW-1:0] h_val;
  logic [AW-1:0] h_addr;
  logic          h_rdy, h_exc, h_mispred;
  logic          head_done, alloc_fire, retire, cdb_take;
  logic [NSRC-1:0] look_rdy;
  logic [NSRC-1:0][DW-1:0] look_val;

  assign a_kind = kind_e'(alloc_kind);

  // Retirement decode at the head
  assign head_done      = !empty && h_rdy;
  assign exc_raise      = head_done && h_exc;
  assign redirect_valid = head_done && !h_exc && h_mispred;
  assign flush          = exc_raise || redirect_valid;
  assign rf_we          = head_done && !h_exc && (h_kind == K_ALU);
  assign mem_we         = head_done && !h_exc && (h_kind == K_STORE);
  assign retire         = head_done && !flush;
  assign rf_waddr       = h_dest;
  assign rf_wdata       = h_val;
  assign mem_addr       = h_addr;
  assign mem_wdata      = h_val;
  assign exc_tag        = head_idx;
  assign redirect_pc    = h_addr;

  // Allocation stream and result capture
  assign alloc_ready = !full && rs_free && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_idx;
  assign cdb_take    = cdb_valid && !flush;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(alloc_fire), .pop(retire), .flush(flush),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full), .empty(empty)
  );

  rob_map #(.NREG(NREG), .DEPTH(DEPTH), .NSRC(NSRC)) u_map (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .set_en(alloc_fire && a_kind == K_ALU), .set_reg(alloc_dest), .set_tag(tail_idx),
    .clr_en(rf_we), .clr_reg(h_dest), .clr_tag(head_idx),
    .look_reg(src_reg), .look_pend(src_pend), .look_tag(src_tag)
  );

  rob_slots #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW), .AW(AW), .NSRC(NSRC)) u_slots (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_en(alloc_fire), .alloc_idx(tail_idx), .alloc_kind(a_kind),
    .alloc_dest(alloc_dest), .alloc_pt(alloc_pred_taken),
    .wr_en(cdb_take), .wr_idx(cdb_tag), .wr_val(cdb_value), .wr_addr(cdb_addr),
    .wr_exc(cdb_exc), .wr_taken(cdb_taken),
    .free_en(retire), .free_idx(head_idx), .head_idx(head_idx),
    .h_kind(h_kind), .h_dest(h_dest), .h_val(h_val), .h_addr(h_addr),
    .h_rdy(h_rdy), .h_exc(h_exc), .h_mispred(h_mispred),
    .look_idx(src_tag), .look_rdy(look_rdy), .look_val(look_val)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_fwd
    assign src_hit[s]   = src_pend[s] && look_rdy[s];
    assign src_value[s] = look_val[s];
  end
endmodule

// File: tb/sim_rob_top.sv
`timescale 1ns/1ps
module sim_rob_top;
  localparam int DEPTH = 8, NREG = 16, DW = 32, AW = 32, NSRC = 2;
  localparam int RW = 4, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic alloc_valid, alloc_ready, alloc_pred_taken, rs_free;
  logic [1:0] alloc_kind;
  logic [RW-1:0] alloc_dest;
  logic [IW-1:0] alloc_tag;
  logic [NSRC-1:0][RW-1:0] src_reg;
  logic [NSRC-1:0] src_pend, src_hit;
  logic [NSRC-1:0][IW-1:0] src_tag;
  logic [NSRC-1:0][DW-1:0] src_value;
  logic cdb_valid, cdb_exc, cdb_taken;
  logic [IW-1:0] cdb_tag;
  logic [DW-1:0] cdb_value;
  logic [AW-1:0] cdb_addr;
  logic rf_we, mem_we, exc_raise, flush, redirect_valid;
  logic [RW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata, mem_wdata;
  logic [AW-1:0] mem_addr, redirect_pc;
  logic [IW-1:0] exc_tag;

  rob_top #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW), .AW(AW), .NSRC(NSRC)) u0 (.*);

  int errs = 0, checks = 0;
  bit done = 0;

  // Behavioural reference state
  int m_kind[DEPTH];
  int m_dest[DEPTH];
  logic [DW-1:0] m_val[DEPTH];
  logic [AW-1:0] m_addr[DEPTH];
  bit m_rdy[DEPTH], m_exc[DEPTH], m_pt[DEPTH], m_at[DEPTH], m_bsy[DEPTH];
  int m_head = 0, m_tail = 0, m_cnt = 0;
  bit mb[NREG];
  int mt[NREG];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    alloc_valid = 0; alloc_kind = 0; alloc_dest = 0; alloc_pred_taken = 0; rs_free = 1;
    src_reg = '0; cdb_valid = 0; cdb_tag = 0; cdb_value = 0; cdb_addr = 0; cdb_exc = 0; cdb_taken = 0;
    for (int r = 0; r < NREG; r++) begin mb[r] = 0; mt[r] = 0; end
    for (int i = 0; i < DEPTH; i++) begin m_rdy[i] = 0; m_bsy[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk("R1", "reset alloc_ready", alloc_ready, 1);
    chk("R1", "reset alloc_tag", alloc_tag, 0);
    chk("R5", "reset rf_we", rf_we, 0);
    chk("R10", "reset flush", flush, 0);
    chk("R4", "reset src_pend", src_pend, 0);

    for (int cyc = 0; cyc < 5000; cyc++) begin
      int h, cand[$];
      bit hok, e_exc, e_mis, e_fl, e_rf, e_mem, e_ar;
      @(negedge clk);
      // Stimulus
      if (cyc < 24) begin
        rs_free = 1; alloc_valid = 1; cdb_valid = 0;
      end else begin
        rs_free = ($urandom % 8) != 0;
        alloc_valid = ((cyc / 200) % 4 == 3) ? (($urandom % 4) == 0) : (($urandom % 3) != 0);
      end
      begin
        int k = $urandom % 10;
        alloc_kind = (k < 6) ? 2'd0 : (k < 8) ? 2'd1 : 2'd2;
      end
      alloc_dest = RW'($urandom % 4);
      alloc_pred_taken = $urandom % 2;
      for (int s = 0; s < NSRC; s++) src_reg[s] = RW'($urandom % 5);
      cand.delete();
      for (int o = 0; o < m_cnt; o++) begin
        int ix = (m_head + o) % DEPTH;
        if (m_bsy[ix] && !m_rdy[ix]) cand.push_back(ix);
      end
      cdb_valid = 0;
      if (cyc >= 24 && cand.size() > 0 && ($urandom % 10) < 7) begin
        int t = cand[$urandom % cand.size()];
        cdb_valid = 1;
        cdb_tag = IW'(t);
        cdb_value = $urandom;
        cdb_addr = $urandom;
        cdb_exc = ($urandom % 40) == 0;
        cdb_taken = (m_kind[t] == 2) ? ((($urandom % 4) == 0) ? !m_pt[t] : m_pt[t]) : 1'($urandom % 2);
      end
      #1;
      // Expected outputs from reference state
      h = m_head;
      hok = (m_cnt > 0) && m_rdy[h];
      e_exc = hok && m_exc[h];
      e_mis = hok && !m_exc[h] && m_kind[h] == 2 && (m_pt[h] != m_at[h]);
      e_fl = e_exc || e_mis;
      e_rf = hok && !m_exc[h] && m_kind[h] == 0;
      e_mem = hok && !m_exc[h] && m_kind[h] == 1;
      e_ar = (m_cnt < DEPTH) && rs_free && !e_fl;
      if (e_fl) chk("R10", "alloc_ready in flush", alloc_ready, 0);
      else if (m_cnt == DEPTH) chk("R2", "alloc_ready when full", alloc_ready, 0);
      else chk("R1", "alloc_ready", alloc_ready, e_ar);
      chk("R1", "alloc_tag", alloc_tag, m_tail);
      chk("R5", "rf_we", rf_we, e_rf);
      if (e_rf) begin
        chk("R5", "rf_waddr", rf_waddr, m_dest[h]);
        chk("R5", "rf_wdata", rf_wdata, m_val[h]);
      end
      chk("R6", "mem_we", mem_we, e_mem);
      if (e_mem) begin
        chk("R6", "mem_addr", mem_addr, m_addr[h]);
        chk("R6", "mem_wdata", mem_wdata, m_val[h]);
      end
      chk("R8", "exc_raise", exc_raise, e_exc);
      if (e_exc) chk("R8", "exc_tag", exc_tag, h);
      chk("R9", "flush", flush, e_fl);
      chk("R9", "redirect_valid", redirect_valid, e_mis);
      if (e_mis) chk("R9", "redirect_pc", redirect_pc, m_addr[h]);
      for (int s = 0; s < NSRC; s++) begin
        int r = int'(src_reg[s]);
        chk("R7", "src_pend", src_pend[s], mb[r]);
        if (mb[r]) begin
          chk("R4", "src_tag", src_tag[s], mt[r]);
          chk("R3", "src_hit", src_hit[s], m_rdy[mt[r]]);
          if (m_rdy[mt[r]]) chk("R4", "src_value", src_value[s], m_val[mt[r]]);
        end
      end
      // Reference state update for the coming edge
      if (e_fl) begin
        for (int i = 0; i < DEPTH; i++) begin m_rdy[i] = 0; m_bsy[i] = 0; end
        for (int r = 0; r < NREG; r++) mb[r] = 0;
        m_head = 0; m_tail = 0; m_cnt = 0;
      end else begin
        if (hok) begin
          if (e_rf && mb[m_dest[h]] && mt[m_dest[h]] == h) mb[m_dest[h]] = 0;
          m_bsy[h] = 0; m_rdy[h] = 0;
          m_head = (h + 1) % DEPTH;
          m_cnt--;
        end
        if (cdb_valid && m_bsy[cdb_tag]) begin
          m_val[cdb_tag] = cdb_value; m_addr[cdb_tag] = cdb_addr;
          m_exc[cdb_tag] = cdb_exc; m_at[cdb_tag] = cdb_taken; m_rdy[cdb_tag] = 1;
        end
        if (alloc_valid && e_ar) begin
          m_kind[m_tail] = int'(alloc_kind); m_dest[m_tail] = int'(alloc_dest);
          m_pt[m_tail] = alloc_pred_taken; m_bsy[m_tail] = 1; m_rdy[m_tail] = 0; m_exc[m_tail] = 0;
          if (alloc_kind == 2'd0) begin mb[alloc_dest] = 1; mt[alloc_dest] = m_tail; end
          m_tail = (m_tail + 1) % DEPTH;
          m_cnt++;
        end
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule